// File: doc/BRIEF.md
# Watchdog Timer with Guarded Control Register

This block is a watchdog timer. One 8-bit control register holds its settings: a window-mode enable, a freeze-while-debugging flag and a 3-bit rate selector. Bit 5 is a write-guard that is not stored. Writes follow access rules that depend on whether the chip is in special mode or normal mode. In normal mode, the window and rate fields may be written only once after reset. A write that leaves them unchanged still uses up that single chance.

The counter advances on tick enables from one of two clock sources: an internal RC source or an oscillator. The selection can change at run time, and any change restarts the timeout period. The counter halts in stop mode unless the pseudo-stop conditions hold. It also holds while a debugger is active and the freeze flag is set. On expiry, a one-cycle pulse is issued so that a reset controller outside the block can act on it. The rate and window presets are loaded while the synchronous reset is asserted.

Top module: `guard_timer`

## Requirements
- R1: While `rst` is high, the register loads the window bit (bit 7) from `preset_win` and the rate field (bits 2:0) from `preset_rate`. The freeze bit (bit 6) clears. Bits 5:3 always read 0, and `timeout` is 0 after reset.
- R2: The freeze bit (bit 6) takes any written value in special mode. In normal mode a write can only set it, and writing 0 leaves it unchanged.
- R3: The window and rate fields are updated only by a write whose bit 5 is 0. In special mode every such write counts. In normal mode only the first such write after reset counts, and later writes leave both fields unchanged.
- R4: Writing 000 to the rate field leaves the rate unchanged, and writing 0 to the window bit leaves it unchanged. An unmasked normal-mode write of this kind still uses up the single write.
- R5: In normal mode the period restarts (count back to zero) on any of three events: an accepted write with a non-zero rate, an accepted write with bit 7 set, or a write that sets the freeze bit while it was 0.
- R6: In special mode, every write to the register restarts the period, masked or not.
- R7: The count advances on `osc_tick` when `use_osc && osc_valid` is true, and on `rc_tick` otherwise. Any change of that selection, including `osc_valid` falling, restarts the period.
- R8: While `stop_mode` is high, the count holds. The exception is when `pseudo_stop`, `osc_en` and the oscillator selection are all true, in which case counting continues.
- R9: With a rate of 000 the counter is idle and never times out. A rate r from 1 to 7 gives `timeout` as a one-cycle pulse after 2^(BASE_LOG2+STEP_LOG2*r) ticks, and the count then starts again from zero.
- R10: While `debug_active` and the freeze bit are both 1, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, also the preset load strobe |
| special_mode | input | 1 | 1 = special mode access rules, 0 = normal mode |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (7 window, 6 freeze, 5 write-guard, 2:0 rate) |
| rd_data | output | 8 | Register readback |
| preset_win | input | 1 | Reset-time value for the window bit |
| preset_rate | input | 3 | Reset-time value for the rate field |
| use_osc | input | 1 | Requests the oscillator as the count source |
| osc_valid | input | 1 | Oscillator is running and usable |
| rc_tick | input | 1 | Tick enable from the internal RC source |
| osc_tick | input | 1 | Tick enable from the oscillator |
| stop_mode | input | 1 | Chip is in stop mode |
| pseudo_stop | input | 1 | Stop mode is the pseudo variant |
| osc_en | input | 1 | Oscillator kept enabled during stop |
| debug_active | input | 1 | Debugger has the core halted |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
A wrong access-rule state has two visible effects. The first is a wrong `rd_data` on the cycle after the offending write. The second is a period that restarts when it should not, or fails to restart when it should. The second shows up only at the next expected or unexpected `timeout` pulse, up to one full period later. A wrong count or a wrong source selection first appears as a `timeout` pulse that comes early, comes late or is missing. The bench therefore compares `timeout` and `rd_data` with a reference on every clock. It uses short bench periods so that every such deviation becomes visible within a few dozen cycles.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int REG_W    = 8;
  localparam int RATE_W   = 3;
  localparam int POS_WIN  = 7;
  localparam int POS_FRZ  = 6;
  localparam int POS_MASK = 5;
  localparam int NUM_RATE = 1 << RATE_W;

  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             preset_win,
  input  rate_t            preset_rate,
  output logic             frz,
  output rate_t            rate,
  output logic             wr_restart,
  output logic [REG_W-1:0] rd_data
);
  logic  win_q, frz_q, used_q;
  rate_t rate_q;
  logic  unguarded, accept, rate_nz, frz_rise;
  logic  rsvd_unused;

  assign rsvd_unused = ^wr_data[POS_MASK-1:RATE_W];

  always_comb begin
    unguarded = !wr_data[POS_MASK];
    accept    = wr_en && unguarded && (special_mode || !used_q);
    rate_nz   = wr_data[RATE_W-1:0] != '0;
    frz_rise  = wr_en && wr_data[POS_FRZ] && !frz_q;
    if (special_mode)
      wr_restart = wr_en;
    else
      wr_restart = (accept && (rate_nz || wr_data[POS_WIN])) || frz_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= preset_win;
      frz_q  <= 1'b0;
      rate_q <= preset_rate;
      used_q <= 1'b0;
    end else if (wr_en) begin
      if (special_mode)
        frz_q <= wr_data[POS_FRZ];
      else if (wr_data[POS_FRZ])
        frz_q <= 1'b1;
      if (accept) begin
        if (rate_nz)          rate_q <= wr_data[RATE_W-1:0];
        if (wr_data[POS_WIN]) win_q  <= 1'b1;
        if (!special_mode)    used_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data                = '0;
    rd_data[POS_WIN]       = win_q;
    rd_data[POS_FRZ]       = frz_q;
    rd_data[RATE_W-1:0]    = rate_q;
  end

  assign frz  = frz_q;
  assign rate = rate_q;

  AST_FRZ_STICKY_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !special_mode) |=> frz_q); // R2
  AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[POS_MASK]) |=> ($stable(rate_q) && $stable(win_q))); // R3
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (used_q && !special_mode) |=> ($stable(rate_q) && $stable(win_q))); // R3
  AST_ZERO_RATE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[RATE_W-1:0] == '0) |=> $stable(rate_q)); // R4
endmodule

// File: rtl/gt_tick_sel.sv
module gt_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic use_osc,
  input  logic osc_valid,
  input  logic rc_tick,
  input  logic osc_tick,
  input  logic stop_mode,
  input  logic pseudo_stop,
  input  logic osc_en,
  output logic tick,
  output logic awake,
  output logic sel_restart
);
  logic sel_now, sel_q;

  assign sel_now = use_osc && osc_valid;

  always_ff @(posedge clk) begin
    sel_q <= sel_now;
  end

  assign sel_restart = (sel_now != sel_q) && !rst;
  assign tick        = sel_now ? osc_tick : rc_tick;
  assign awake       = !stop_mode || (pseudo_stop && sel_now && osc_en);
endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import gt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  rate_t rate,
  input  logic  tick,
  input  logic  run,
  input  logic  restart,
  output logic  timeout
);
  localparam int CW = BASE_LOG2 + STEP_LOG2 * (NUM_RATE - 1);
  localparam logic [CW:0]   ONE_W = {{CW{1'b0}}, 1'b1};
  localparam logic [CW-1:0] INC   = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW:0]   last;
  logic          at_end, to_q;
  int            shamt;

  always_comb begin
    shamt  = BASE_LOG2 + STEP_LOG2 * int'(rate);
    last   = (ONE_W << shamt) - ONE_W;
    at_end = {1'b0, cnt_q} >= last;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (run && tick) begin
        if (at_end) begin
          cnt_q <= '0;
          to_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + INC;
        end
      end
    end
  end

  assign timeout = to_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    to_q |=> !to_q); // R9
  AST_IDLE_RATE: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |=> !to_q); // R9
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt_q)); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0 && !to_q)); // R5
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             preset_win,
  input  logic [RATE_W-1:0] preset_rate,
  input  logic             use_osc,
  input  logic             osc_valid,
  input  logic             rc_tick,
  input  logic             osc_tick,
  input  logic             stop_mode,
  input  logic             pseudo_stop,
  input  logic             osc_en,
  input  logic             debug_active,
  output logic             timeout
);
  logic  frz, wr_restart, tick, awake, sel_restart, run;
  rate_t rate;

  gt_regs u_regs (
    .clk(clk), .rst(rst), .special_mode(special_mode),
    .wr_en(wr_en), .wr_data(wr_data),
    .preset_win(preset_win), .preset_rate(preset_rate),
    .frz(frz), .rate(rate), .wr_restart(wr_restart), .rd_data(rd_data)
  );

  gt_tick_sel u_sel (
    .clk(clk), .rst(rst), .use_osc(use_osc), .osc_valid(osc_valid),
    .rc_tick(rc_tick), .osc_tick(osc_tick),
    .stop_mode(stop_mode), .pseudo_stop(pseudo_stop), .osc_en(osc_en),
    .tick(tick), .awake(awake), .sel_restart(sel_restart)
  );

  assign run = awake && (rate != '0) && !(debug_active && frz);

  gt_counter #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_cnt (
    .clk(clk), .rst(rst), .rate(rate), .tick(tick), .run(run),
    .restart(wr_restart || sel_restart), .timeout(timeout)
  );

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (debug_active && frz && !wr_restart && !sel_restart) |=> !timeout); // R10
endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic special_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic preset_win = 1'b0;
  logic [2:0] preset_rate = 3'd0;
  logic use_osc = 1'b0, osc_valid = 1'b1, rc_tick = 1'b0, osc_tick = 1'b1;
  logic stop_mode = 1'b0, pseudo_stop = 1'b0, osc_en = 1'b0, debug_active = 1'b0;
  logic timeout;

  int total = 0, bad = 0, to_cnt = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_win, m_frz, m_used, m_sel, m_to;
  int m_rate, m_cnt;

  always #5 clk = ~clk;

  guard_timer #(.BASE_LOG2(2), .STEP_LOG2(1)) uut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .preset_win(preset_win),
    .preset_rate(preset_rate), .use_osc(use_osc), .osc_valid(osc_valid),
    .rc_tick(rc_tick), .osc_tick(osc_tick), .stop_mode(stop_mode),
    .pseudo_stop(pseudo_stop), .osc_en(osc_en), .debug_active(debug_active),
    .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_next();
    bit sel_now, tk, rs, runok, acc;
    int lim;
    if (rst) begin
      m_win = preset_win; m_frz = 0; m_rate = preset_rate; m_used = 0;
      m_sel = use_osc & osc_valid; m_cnt = 0; m_to = 0;
      return;
    end
    sel_now = use_osc & osc_valid;
    rs = (sel_now != m_sel);
    acc = wr_en && !wr_data[5] && (special_mode || !m_used);
    if (wr_en) begin
      if (special_mode) rs = 1;
      else if ((acc && (wr_data[2:0] != 0 || wr_data[7])) || (wr_data[6] && !m_frz)) rs = 1;
    end
    runok = (m_rate != 0) && (!stop_mode || (pseudo_stop && sel_now && osc_en))
            && !(debug_active && m_frz);
    tk  = sel_now ? osc_tick : rc_tick;
    lim = 1 << (2 + m_rate);
    if (rs) begin m_cnt = 0; m_to = 0; end
    else begin
      m_to = 0;
      if (runok && tk) begin
        if (m_cnt >= lim - 1) begin m_cnt = 0; m_to = 1; end
        else m_cnt++;
      end
    end
    if (wr_en) begin
      if (special_mode) m_frz = wr_data[6];
      else if (wr_data[6]) m_frz = 1;
      if (acc) begin
        if (wr_data[2:0] != 0) m_rate = wr_data[2:0];
        if (wr_data[7]) m_win = 1;
        if (!special_mode) m_used = 1;
      end
    end
    m_sel = sel_now;
  endtask

  task automatic step();
    logic [7:0] exp_rd;
    rc_tick = cyc[0];
    model_next();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    exp_rd = {m_win, m_frz, 3'b000, m_rate[2:0]};
    chk(rd_data == exp_rd, {cur_req, " rd_data per-cycle"}, rd_data, exp_rd);
    chk(timeout == m_to, {cur_req, " timeout per-cycle"}, timeout, m_to);
    if (timeout) to_cnt++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input bit w, input logic [2:0] r);
    preset_win = w; preset_rate = r; rst = 1'b1;
    run(2);
    rst = 1'b0;
    to_cnt = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset load, R9 period on rc ticks
    cur_req = "R1";
    do_reset(1'b1, 3'd1);
    chk(rd_data == 8'h81, "R1 preset readback", rd_data, 8'h81);
    chk(timeout == 1'b0, "R1 timeout after reset", timeout, 0);
    cur_req = "R9";
    run(40);
    chk(to_cnt == 2, "R9 two expiries in 20 rc ticks", to_cnt, 2);

    // R2 / R4 / R3 normal mode
    cur_req = "R4";
    wr(8'h40);
    chk(rd_data == 8'hC1, "R4 zero rate and window kept", rd_data, 8'hC1);
    cur_req = "R3";
    wr(8'h03);
    chk(rd_data == 8'hC1, "R3 second normal write ignored", rd_data, 8'hC1);
    cur_req = "R2";
    wr(8'h00);
    chk(rd_data == 8'hC1, "R2 normal freeze not cleared", rd_data, 8'hC1);

    // R9 idle, R3 guard, R5 restart
    cur_req = "R9";
    do_reset(1'b0, 3'd0);
    chk(rd_data == 8'h00, "R1 zero preset readback", rd_data, 8'h00);
    run(60);
    chk(to_cnt == 0, "R9 rate zero never expires", to_cnt, 0);
    cur_req = "R3";
    wr(8'h21);
    chk(rd_data == 8'h00, "R3 guarded write ignored", rd_data, 8'h00);
    wr(8'h01);
    chk(rd_data == 8'h01, "R3 first unguarded write taken", rd_data, 8'h01);
    cur_req = "R5";
    to_cnt = 0;
    run(10);
    wr(8'h40);
    to_cnt = 0;
    run(12);
    chk(to_cnt == 0, "R5 freeze rise restarted period", to_cnt, 0);
    run(8);
    chk(to_cnt == 1, "R5 expiry after restart", to_cnt, 1);

    // R3 / R2 / R6 special mode
    special_mode = 1'b1;
    cur_req = "R3";
    do_reset(1'b0, 3'd1);
    wr(8'h02);
    chk(rd_data == 8'h02, "R3 special rewrite 1", rd_data, 8'h02);
    wr(8'h05);
    chk(rd_data == 8'h05, "R3 special rewrite 2", rd_data, 8'h05);
    cur_req = "R2";
    wr(8'h40);
    chk(rd_data == 8'h45, "R2 special freeze set", rd_data, 8'h45);
    wr(8'h00);
    chk(rd_data == 8'h05, "R2 special freeze clear", rd_data, 8'h05);
    cur_req = "R6";
    wr(8'h01);
    to_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      run(9);
      wr(8'h20);
    end
    chk(to_cnt == 0, "R6 every special write restarts", to_cnt, 0);
    chk(rd_data == 8'h01, "R6 guarded writes kept rate", rd_data, 8'h01);
    special_mode = 1'b0;

    // R7 clock selection
    cur_req = "R7";
    use_osc = 1'b1; osc_valid = 1'b1;
    do_reset(1'b0, 3'd1);
    run(9);
    chk(to_cnt == 1, "R7 osc ticks every cycle", to_cnt, 1);
    run(5);
    osc_valid = 1'b0;
    run(10);
    chk(to_cnt == 1, "R7 loss of osc restarted period", to_cnt, 1);
    osc_valid = 1'b1;

    // R8 stop mode
    cur_req = "R8";
    use_osc = 1'b0;
    do_reset(1'b0, 3'd1);
    stop_mode = 1'b1;
    run(60);
    chk(to_cnt == 0, "R8 stop halts count", to_cnt, 0);
    pseudo_stop = 1'b1; osc_en = 1'b1;
    run(40);
    chk(to_cnt == 0, "R8 pseudo stop on rc still halts", to_cnt, 0);
    use_osc = 1'b1;
    run(20);
    chk(to_cnt == 2, "R8 pseudo stop on osc keeps counting", to_cnt, 2);
    stop_mode = 1'b0; pseudo_stop = 1'b0; osc_en = 1'b0;

    // R10 freeze while debugging
    cur_req = "R10";
    do_reset(1'b0, 3'd1);
    wr(8'h40);
    debug_active = 1'b1;
    to_cnt = 0;
    run(40);
    chk(to_cnt == 0, "R10 freeze with debug holds", to_cnt, 0);
    debug_active = 1'b0;
    run(20);
    chk(to_cnt == 2, "R10 resumes after debug", to_cnt, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule